// File: doc/BRIEF.md
# SPI-Accessed Amplifier Power Setting Table

This block holds a small table of byte-wide amplifier control settings. Software reaches the table through a byte-level serial command interface. The bit-level shifter sits outside this block. Each transferred byte arrives as a one-cycle strobe alongside an active-low chip-select level.

The first strobed byte after chip select falls is a header. It sets the transfer direction and chooses between single-byte and burst access. Every later byte reads or writes the entry at an internal index. That index moves up by one after each byte that touches the table, wraps from the last entry back to the first, and returns to zero only while chip select is high. To read back a byte that was just written, the host must therefore take chip select high first.

A separate power selector picks the entry that drives the amplifier control output, and that output follows the table combinationally. Holding the sleep input high wipes every entry to zero.

Top module: `pwr_table_spi`

## Requirements
- R1: While reset is asserted and just after it, every entry is zero, so `amp_ctrl` is 0 for every selector value and `rd_byte` is 0.
- R2: The first byte strobed after `cs_n` falls is a header. Bit 7 gives the direction (0 write, 1 read) and bit 6 gives the mode (1 burst, 0 single). The other header bits are not decoded. A header byte touches no entry and leaves `rd_byte` at 0.
- R3: In a burst write, data bytes land in successive entries starting at index 0.
- R4: During a read, `rd_byte` shows the entry at the current index in the same cycle as the byte strobe. In every other cycle `rd_byte` is 0.
- R5: The index goes up by one after each data byte that accesses the table, and wraps from the last entry to 0. The ninth byte of a burst therefore hits entry 0 again.
- R6: While `cs_n` is high, the index is held at 0 and the next strobed byte is taken as a header.
- R7: In single mode, only the first data byte after the header accesses the table. Later bytes are ignored until `cs_n` goes high, and they read as 0.
- R8: While `sleep` is high, every entry is cleared on the clock edge. A write that arrives during sleep is dropped.
- R9: `amp_ctrl` equals the entry addressed by `pwr_sel`, combinationally.
- R10: Reads do not alter the table.
- R11: Bytes strobed while `cs_n` is high are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Chip select level, active low |
| byte_vld | input | 1 | One-cycle strobe marking a transferred byte |
| wr_byte | input | DATA_W | Byte received from the host |
| rd_byte | output | DATA_W | Byte returned to the host during a read access |
| sleep | input | 1 | Clears the table while high |
| pwr_sel | input | IDX_W | Selects the entry that drives the amplifier |
| amp_ctrl | output | DATA_W | Amplifier control setting |

## Verification
The bench builds the block with its defaults: eight entries of eight bits. With eight entries, a nine-byte burst reaches the wrap from index 7 to 0, and the 3-bit selector can address every entry directly, so the bench can read back each wrapped entry through `amp_ctrl`. Single and burst modes are both run in each direction, with idle cycles inside a burst. The bench also covers strobes while deselected, writes that meet sleep, and reads that follow a chip-select cycle.

// File: rtl/pt_pkg.sv
// Shared types for the power setting table.
// Assumes the header is at least 8 bits wide.
package pt_pkg;
    localparam int HDR_RD_BIT    = 7;
    localparam int HDR_BURST_BIT = 6;

    typedef enum logic [1:0] {
        PH_HDR  = 2'd0,
        PH_DATA = 2'd1,
        PH_HOLD = 2'd2
    } phase_t;

    typedef struct packed {
        logic rd;
        logic burst;
    } hdr_t;
endpackage

// File: rtl/pt_seq.sv
// Transfer sequencer: decodes the header byte and decides which strobed bytes
// access the table. Assumes byte_vld is a one-cycle strobe per byte.
module pt_seq #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              byte_vld,
    input  logic [DATA_W-1:0] wr_byte,
    output logic              acc,
    output logic              wr_en,
    output logic              rd_en
);
    import pt_pkg::*;

    phase_t phase_q;
    hdr_t   hdr_q;

    // Track the transfer phase and capture the header fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_HDR;
            hdr_q   <= '0;
        end else if (cs_n) begin
            phase_q <= PH_HDR;
        end else if (byte_vld) begin
            case (phase_q)
                PH_HDR: begin
                    hdr_q.rd    <= wr_byte[HDR_RD_BIT];
                    hdr_q.burst <= wr_byte[HDR_BURST_BIT];
                    phase_q     <= PH_DATA;
                end
                PH_DATA: if (!hdr_q.burst) phase_q <= PH_HOLD;
                default: phase_q <= PH_HOLD;
            endcase
        end
    end

    // A data byte accesses the table only while selected and in the data phase.
    always_comb begin
        acc   = !cs_n && byte_vld && (phase_q == PH_DATA);
        wr_en = acc && !hdr_q.rd;
        rd_en = acc && hdr_q.rd;
    end
endmodule

// File: rtl/pt_index.sv
// Shared access index: held at zero while deselected, advances after each
// access and wraps at the last entry. Works for any entry count.
module pt_index #(
    parameter int ENTRY_COUNT = 8,
    localparam int IDX_W = $clog2(ENTRY_COUNT)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_n,
    input  logic             step,
    output logic [IDX_W-1:0] idx
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRY_COUNT - 1);

    logic [IDX_W-1:0] idx_q;

    // Home on deselect, otherwise step with wrap.
    always_ff @(posedge clk) begin
        if (!rst_n || cs_n)   idx_q <= '0;
        else if (step)        idx_q <= (idx_q == LAST) ? '0 : idx_q + 1'b1;
    end

    assign idx = idx_q;
endmodule

// File: rtl/pt_store.sv
// Register table with one write port, one read port and one selector port.
// Sleep wipes all entries and has priority over a write.
module pt_store #(
    parameter int ENTRY_COUNT = 8,
    parameter int DATA_W = 8,
    localparam int IDX_W = $clog2(ENTRY_COUNT)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wipe,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  sel,
    output logic [DATA_W-1:0] rd_data,
    output logic [DATA_W-1:0] sel_data
);
    logic [DATA_W-1:0] ent [ENTRY_COUNT];

    for (genvar g = 0; g < ENTRY_COUNT; g++) begin : g_ent
        // Each entry clears on reset or sleep and loads on an addressed write.
        always_ff @(posedge clk) begin
            if (!rst_n || wipe)                         ent[g] <= '0;
            else if (wr_en && idx == IDX_W'(g))         ent[g] <= wr_data;
        end
    end

    // Read and selector ports; out-of-range indices read as zero.
    always_comb begin
        rd_data  = '0;
        sel_data = '0;
        for (int i = 0; i < ENTRY_COUNT; i++) begin
            if (idx == IDX_W'(i)) rd_data  = ent[i];
            if (sel == IDX_W'(i)) sel_data = ent[i];
        end
    end
endmodule

// File: rtl/pwr_table_spi.sv
// Top of the power setting table: sequencer, index and storage.
// Assumes a byte-level front end that delivers one strobe per byte.
module pwr_table_spi #(
    parameter int ENTRY_COUNT = 8,
    parameter int DATA_W = 8,
    localparam int IDX_W = $clog2(ENTRY_COUNT)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              byte_vld,
    input  logic [DATA_W-1:0] wr_byte,
    output logic [DATA_W-1:0] rd_byte,
    input  logic              sleep,
    input  logic [IDX_W-1:0]  pwr_sel,
    output logic [DATA_W-1:0] amp_ctrl
);
    logic             acc, wr_en, rd_en;
    logic [IDX_W-1:0] idx;
    logic [DATA_W-1:0] rd_data;

    pt_seq #(.DATA_W(DATA_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .byte_vld(byte_vld),
        .wr_byte(wr_byte), .acc(acc), .wr_en(wr_en), .rd_en(rd_en)
    );

    pt_index #(.ENTRY_COUNT(ENTRY_COUNT)) u_idx (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .step(acc), .idx(idx)
    );

    pt_store #(.ENTRY_COUNT(ENTRY_COUNT), .DATA_W(DATA_W)) u_store (
        .clk(clk), .rst_n(rst_n), .wipe(sleep), .wr_en(wr_en), .idx(idx),
        .wr_data(wr_byte), .sel(pwr_sel), .rd_data(rd_data), .sel_data(amp_ctrl)
    );

    // Drive read data only during a read access.
    always_comb rd_byte = rd_en ? rd_data : '0;
endmodule

// File: rtl/pt_checker.sv
// Protocol checks for pwr_table_spi, attached with bind.
module pt_checker #(
    parameter int ENTRY_COUNT = 8,
    parameter int DATA_W = 8,
    localparam int IDX_W = $clog2(ENTRY_COUNT)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cs_n,
    input logic              byte_vld,
    input logic              sleep,
    input logic [DATA_W-1:0] rd_byte,
    input logic [DATA_W-1:0] amp_ctrl,
    input logic              acc,
    input logic              rd_en,
    input logic [IDX_W-1:0]  idx,
    input logic [1:0]        phase
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRY_COUNT - 1);

    assert_idx_home_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> idx == '0);

    assert_idx_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> idx == (($past(idx) == LAST) ? '0 : $past(idx) + 1'b1));

    assert_out_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |-> rd_byte == '0);

    assert_sleep_wipe_R8: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |=> amp_ctrl == '0);

    assert_cs_gate_R11: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !acc);

    assert_single_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 2'd2 && byte_vld) |-> !acc);
endmodule

bind pwr_table_spi pt_checker #(.ENTRY_COUNT(ENTRY_COUNT), .DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .byte_vld(byte_vld), .sleep(sleep),
    .rd_byte(rd_byte), .amp_ctrl(amp_ctrl), .acc(acc), .rd_en(rd_en),
    .idx(idx), .phase(u_seq.phase_q)
);

// File: tb/pwr_table_spi_test.sv
module pwr_table_spi_test;
    localparam int CLK_PERIOD = 10;

    logic       clk = 0, rst_n = 0, cs_n = 1, byte_vld = 0, sleep = 0;
    logic [7:0] wr_byte = 0;
    logic [2:0] pwr_sel = 0;
    logic [7:0] rd_byte, amp_ctrl;
    int checks = 0, fails = 0;
    bit done = 0;

    pwr_table_spi uut (.clk(clk), .rst_n(rst_n), .cs_n(cs_n), .byte_vld(byte_vld),
        .wr_byte(wr_byte), .rd_byte(rd_byte), .sleep(sleep), .pwr_sel(pwr_sel),
        .amp_ctrl(amp_ctrl));

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct packed {
        logic       cs; logic vld; logic [7:0] din; logic [2:0] sel;
        logic [7:0] exp_out; logic [7:0] exp_amp; logic [3:0] req;
    } vec_t;

    localparam int NV = 23;
    localparam vec_t VECS [NV] = '{
        '{1'b1,1'b0,8'h00,3'd0,8'h00,8'h00,4'd1},  // R1 idle after reset
        '{1'b0,1'b1,8'h40,3'd0,8'h00,8'h00,4'd2},  // R2 header: burst write
        '{1'b0,1'b1,8'h11,3'd0,8'h00,8'h00,4'd3},  // R3 entry 0
        '{1'b0,1'b1,8'h22,3'd0,8'h00,8'h11,4'd3},  // R3 entry 1, R9
        '{1'b0,1'b1,8'h33,3'd1,8'h00,8'h22,4'd9},  // R9 entry 2
        '{1'b0,1'b0,8'h00,3'd2,8'h00,8'h33,4'd9},  // R9
        '{1'b1,1'b0,8'h00,3'd0,8'h00,8'h11,4'd6},  // R6 deselect
        '{1'b0,1'b1,8'hC0,3'd0,8'h00,8'h11,4'd2},  // R2 header: burst read
        '{1'b0,1'b1,8'h00,3'd0,8'h11,8'h11,4'd4},  // R4 index 0
        '{1'b0,1'b1,8'h00,3'd0,8'h22,8'h11,4'd4},  // R4 index 1
        '{1'b0,1'b0,8'h00,3'd0,8'h00,8'h11,4'd4},  // R4 gap reads 0
        '{1'b0,1'b1,8'h00,3'd0,8'h33,8'h11,4'd4},  // R4 index 2
        '{1'b1,1'b0,8'h00,3'd0,8'h00,8'h11,4'd10}, // R10 reads left entry 0
        '{1'b0,1'b1,8'h00,3'd0,8'h00,8'h11,4'd2},  // R2 header: single write
        '{1'b0,1'b1,8'h5A,3'd0,8'h00,8'h11,4'd7},  // R7 first data byte
        '{1'b0,1'b1,8'h77,3'd0,8'h00,8'h5A,4'd7},  // R7 ignored byte
        '{1'b1,1'b0,8'h00,3'd1,8'h00,8'h22,4'd7},  // R7 entry 1 kept
        '{1'b0,1'b1,8'h80,3'd0,8'h00,8'h5A,4'd2},  // R2 header: single read
        '{1'b0,1'b1,8'h00,3'd0,8'h5A,8'h5A,4'd7},  // R7 one read
        '{1'b0,1'b1,8'h00,3'd0,8'h00,8'h5A,4'd7},  // R7 next read blocked
        '{1'b1,1'b1,8'h40,3'd0,8'h00,8'h5A,4'd11}, // R11 strobe while deselected
        '{1'b1,1'b1,8'h99,3'd0,8'h00,8'h5A,4'd11}, // R11
        '{1'b1,1'b0,8'h00,3'd0,8'h00,8'h5A,4'd11}  // R11 entry 0 kept
    };

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic cyc(input logic c, input logic v, input logic [7:0] d);
        @(negedge clk);
        cs_n = c; byte_vld = v; wr_byte = d;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #2;
        for (int s = 0; s < 8; s++) begin
            pwr_sel = 3'(s); #1;
            check("R1 reset amp", amp_ctrl, 8'h00);
        end
        check("R1 reset rd_byte", rd_byte, 8'h00);
        rst_n = 1;
        for (int i = 0; i < NV; i++) begin
            cyc(VECS[i].cs, VECS[i].vld, VECS[i].din);
            pwr_sel = VECS[i].sel;
            #2;
            check($sformatf("R%0d vec %0d rd_byte", VECS[i].req, i), rd_byte, VECS[i].exp_out);
            check($sformatf("R%0d vec %0d amp", VECS[i].req, i), amp_ctrl, VECS[i].exp_amp);
        end
        // R5 wrap: nine-byte burst write, ninth lands in entry 0
        cyc(0, 1, 8'h40);
        for (int k = 0; k < 9; k++) cyc(0, 1, 8'hA0 + 8'(k));
        cyc(1, 0, 0);
        #2;
        for (int s = 0; s < 8; s++) begin
            pwr_sel = 3'(s); #1;
            check("R5 wrap", amp_ctrl, (s == 0) ? 8'hA8 : 8'hA0 + 8'(s));
        end
        // R5 wrapped read: ninth read returns entry 0 again
        cyc(0, 1, 8'hC0);
        for (int k = 0; k < 8; k++) cyc(0, 1, 0);
        cyc(0, 1, 0); #2;
        check("R5 wrapped read", rd_byte, 8'hA8);
        cyc(1, 0, 0);
        // R8 sleep wipes the table
        @(negedge clk); sleep = 1;
        @(negedge clk); sleep = 0; #2;
        for (int s = 0; s < 8; s++) begin
            pwr_sel = 3'(s); #1;
            check("R8 sleep wipe", amp_ctrl, 8'h00);
        end
        // R8 write during sleep is dropped
        cyc(0, 1, 8'h40);
        cyc(0, 1, 8'h55); sleep = 1;
        cyc(1, 0, 0); sleep = 0;
        #2; pwr_sel = 0; #1;
        check("R8 write in sleep", amp_ctrl, 8'h00);
        // R1 reset clears a written entry
        cyc(0, 1, 8'h40);
        cyc(0, 1, 8'h3C);
        cyc(1, 0, 0); #2;
        check("R3 single-entry burst", amp_ctrl, 8'h3C);
        rst_n = 0;
        @(negedge clk); #2;
        check("R1 reset clears", amp_ctrl, 8'h00);
        rst_n = 1;
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual hung expected done");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule